// File: doc/BRIEF.md
# Dual-Channel Serial Interrupt Vectoring

This block keeps the interrupt bookkeeping for a two-channel serial controller. Each channel has two sources, receive and transmit. Each source has a pending flag and an under-service flag. From these flags the block maintains three things:

- a shared six-bit pending register;
- a shared vector byte that reports the most recent interrupt cause;
- one interrupt line, which is the OR of both channels' qualified requests.

Receive has priority over transmit. While a receive interrupt is under service, a new transmit interrupt is noted as pending but does not take the vector. When either source of a channel is cleared, the other source of that channel takes over again if it is still pending. A status-high select chooses between two placements of the cause code inside the vector byte.

The surrounding register-file logic turns bus writes into one-cycle event strobes. It also holds the enable fields and the break status, and presents them as levels. Channel index 0 is channel A and index 1 is channel B.

Top module: `sivec_ctrl`

## Requirements
- R1: After the synchronous active-low reset, the block is in its idle state:
  - the pending register reads 0x00;
  - the vector reads 0x00;
  - the interrupt line is low;
  - all pending and under-service flags are clear.
- R2: Pending register bit positions:
  - channel A: receive is bit 5, transmit is bit 4, external is bit 3;
  - channel B: receive is bit 2, transmit is bit 1, external is bit 0;
  - the two external bits always read 0.
  - A cleared source drops its bit on the next clock.
- R3: Vector codes with the status-high select at 0:
  - idle 0x06; channel A receive 0x0C; channel B receive 0x04; channel A transmit 0x08; channel B transmit 0x00.
- R3 (continued): Vector codes with the status-high select at 1:
  - idle 0x60; channel A receive 0x30; channel B receive 0x20; channel A transmit 0x10; channel B transmit 0x00.
- R4: A receive-set strobe sets the channel's receive pending and receive under-service flags, sets its receive pending bit, and loads its receive code into the vector on the next clock.
- R5: A transmit-set strobe always sets transmit pending. Only when receive is not under service does it also mark transmit under service and load the transmit code into the vector. The transmit pending bit is then set only if the channel's transmit enable is 1.
- R6: Clearing one source of a channel (receive or transmit):
  - clears that source's pending flag, under-service flag and pending bit;
  - loads the idle code into the vector;
  - if the other source of that channel is still pending, that source is re-asserted in the same clock, as if it had just been set, and its code is loaded instead of the idle code.
- R7: The reset-under-service strobe acts as follows:
  - if receive is under service, it clears receive under-service and then re-asserts a pending transmit;
  - otherwise it clears transmit under-service, and the vector and pending register are unchanged.
- R8: Each channel requests an interrupt when any of these holds:
  - its transmit enable is 1 and transmit is pending;
  - its two-bit receive mode (channel A at bits 1:0, channel B at bits 3:2 of the mode port) is 01 or 10, and receive is pending;
  - its break enable and break status are both 1.
- R8 (continued): The interrupt line is the combinational OR of both channels' requests.
- R9: If both channels load the vector in the same clock, channel A's code is stored. Within one channel, simultaneous strobes resolve in this priority order: receive-clear, transmit-clear, receive-set, transmit-set, reset-under-service.
- R10: The status-high select is used only when the vector is loaded. Changing it later does not alter the stored vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_set_i | input | 2 | Receive interrupt set strobe, one per channel |
| tx_set_i | input | 2 | Transmit interrupt set strobe, one per channel |
| rx_clr_i | input | 2 | Receive interrupt clear strobe, one per channel |
| tx_clr_i | input | 2 | Transmit interrupt clear strobe, one per channel |
| ius_rst_i | input | 2 | Reset highest under-service strobe, one per channel |
| tx_ie_i | input | 2 | Transmit interrupt enable, one per channel |
| rx_mode_i | input | 4 | Receive interrupt mode, two bits per channel |
| brk_ie_i | input | 2 | Break interrupt enable, one per channel |
| brk_stat_i | input | 2 | Break status, one per channel |
| stat_hi_i | input | 1 | Selects the high placement of the vector code |
| pend_o | output | 6 | Shared interrupt pending register |
| vec_o | output | 8 | Modified interrupt vector |
| irq_o | output | 1 | Interrupt request line |

## Verification
The bench builds the block with its default parameters:
- two channels;
- an eight-bit vector;
- six pending bits.

With these values every code of both vector placements can be reached. So can the receive-blocks-transmit and clear-then-re-assert orderings on each channel, and the cycle in which both channels load the vector at once. The directed part drives every receive-mode value and the break qualifiers, and applies conflicting strobes to one channel in the same clock.

// File: rtl/sivec_pkg.sv
// Package: shared constants, types and the vector code function.
// Assumes channel index 0 is channel A and index 1 is channel B.
package sivec_pkg;
    localparam int NCH    = 2;
    localparam int VEC_W  = 8;
    localparam int BITS_PER_CH = 3;
    localparam int PEND_W = NCH * BITS_PER_CH;

    typedef enum logic [1:0] {
        VK_NONE = 2'd0,
        VK_RX   = 2'd1,
        VK_TX   = 2'd2
    } vkind_t;

    typedef struct packed {
        logic   load;
        vkind_t kind;
        logic   rx_bit_set;
        logic   rx_bit_clr;
        logic   tx_bit_set;
        logic   tx_bit_clr;
    } chan_upd_t;

    // Vector code for a channel, a cause and the placement select.
    function automatic logic [VEC_W-1:0] vec_code(input int ch, input vkind_t kind, input logic hi);
        logic [VEC_W-1:0] v;
        case (kind)
            VK_RX:   v = (ch == 0) ? (hi ? 8'h30 : 8'h0C) : (hi ? 8'h20 : 8'h04);
            VK_TX:   v = (ch == 0) ? (hi ? 8'h10 : 8'h08) : 8'h00;
            default: v = hi ? 8'h60 : 8'h06;
        endcase
        return v;
    endfunction

    // Pending register bit of a channel's transmit source; receive is one above.
    function automatic int tx_bit_pos(input int ch);
        return (NCH - 1 - ch) * BITS_PER_CH + 1;
    endfunction
endpackage

// File: rtl/sivec_chan.sv
// Module: per-channel receive/transmit interrupt state.
// Resolves the channel's strobes in the fixed priority order:
// receive-clear, transmit-clear, receive-set, transmit-set, reset-under-service.
// It reports the pending-bit and vector updates it wants as one update record.
// Assumes strobes last one cycle; a strobe that loses arbitration is dropped.
module sivec_chan
    import sivec_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      rx_set_i,
    input  logic      tx_set_i,
    input  logic      rx_clr_i,
    input  logic      tx_clr_i,
    input  logic      ius_rst_i,
    input  logic      tx_ie_i,
    output logic      rx_pend_o,
    output logic      tx_pend_o,
    output chan_upd_t upd_o
);
    logic rx_pend_q, rx_svc_q, tx_pend_q, tx_svc_q;
    logic rx_pend_d, rx_svc_d, tx_pend_d, tx_svc_d;

    // Next-state and update decode for the winning strobe.
    always_comb begin
        rx_pend_d = rx_pend_q;
        rx_svc_d  = rx_svc_q;
        tx_pend_d = tx_pend_q;
        tx_svc_d  = tx_svc_q;
        upd_o     = '0;
        upd_o.kind = VK_NONE;
        if (rx_clr_i) begin
            rx_pend_d        = 1'b0;
            rx_svc_d         = 1'b0;
            upd_o.rx_bit_clr = 1'b1;
            upd_o.load       = 1'b1;
            if (tx_pend_q) begin
                tx_svc_d         = 1'b1;
                upd_o.tx_bit_set = tx_ie_i;
                upd_o.kind       = VK_TX;
            end
        end else if (tx_clr_i) begin
            tx_pend_d        = 1'b0;
            tx_svc_d         = 1'b0;
            upd_o.tx_bit_clr = 1'b1;
            upd_o.load       = 1'b1;
            if (rx_pend_q) begin
                rx_svc_d         = 1'b1;
                upd_o.rx_bit_set = 1'b1;
                upd_o.kind       = VK_RX;
            end
        end else if (rx_set_i) begin
            rx_pend_d        = 1'b1;
            rx_svc_d         = 1'b1;
            upd_o.rx_bit_set = 1'b1;
            upd_o.load       = 1'b1;
            upd_o.kind       = VK_RX;
        end else if (tx_set_i) begin
            tx_pend_d = 1'b1;
            if (!rx_svc_q) begin
                tx_svc_d         = 1'b1;
                upd_o.tx_bit_set = tx_ie_i;
                upd_o.load       = 1'b1;
                upd_o.kind       = VK_TX;
            end
        end else if (ius_rst_i) begin
            if (rx_svc_q) begin
                rx_svc_d = 1'b0;
                if (tx_pend_q) begin
                    tx_svc_d         = 1'b1;
                    upd_o.tx_bit_set = tx_ie_i;
                    upd_o.load       = 1'b1;
                    upd_o.kind       = VK_TX;
                end
            end else if (tx_svc_q) begin
                tx_svc_d = 1'b0;
            end
        end
    end

    // Flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_pend_q <= 1'b0;
            rx_svc_q  <= 1'b0;
            tx_pend_q <= 1'b0;
            tx_svc_q  <= 1'b0;
        end else begin
            rx_pend_q <= rx_pend_d;
            rx_svc_q  <= rx_svc_d;
            tx_pend_q <= tx_pend_d;
            tx_svc_q  <= tx_svc_d;
        end
    end

    assign rx_pend_o = rx_pend_q;
    assign tx_pend_o = tx_pend_q;
endmodule

// File: rtl/sivec_merge.sv
// Module: shared pending register and vector register.
// Applies every channel's pending-bit updates.
// Loads the vector from the lowest-index loading channel, so channel A wins.
// Assumes set and clear of the same bit never come from one channel together.
module sivec_merge
    import sivec_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  stat_hi_i,
    input  chan_upd_t [NCH-1:0]   upd_i,
    output logic [PEND_W-1:0]     pend_o,
    output logic [VEC_W-1:0]      vec_o
);
    logic [PEND_W-1:0] pend_q, pend_d;
    logic [VEC_W-1:0]  vec_q, vec_d;

    // Merge per-channel requests into next pending and vector values.
    always_comb begin
        pend_d = pend_q;
        vec_d  = vec_q;
        for (int ch = NCH - 1; ch >= 0; ch--) begin
            if (upd_i[ch].tx_bit_set) pend_d[tx_bit_pos(ch)]     = 1'b1;
            if (upd_i[ch].tx_bit_clr) pend_d[tx_bit_pos(ch)]     = 1'b0;
            if (upd_i[ch].rx_bit_set) pend_d[tx_bit_pos(ch) + 1] = 1'b1;
            if (upd_i[ch].rx_bit_clr) pend_d[tx_bit_pos(ch) + 1] = 1'b0;
            if (upd_i[ch].load) vec_d = vec_code(ch, upd_i[ch].kind, stat_hi_i);
        end
    end

    // Shared registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            vec_q  <= '0;
        end else begin
            pend_q <= pend_d;
            vec_q  <= vec_d;
        end
    end

    assign pend_o = pend_q;
    assign vec_o  = vec_q;
endmodule

// File: rtl/sivec_irq.sv
// Module: qualifies each channel's request and ORs the requests into one line.
// Purely combinational; assumes the flags come from registers.
module sivec_irq
    import sivec_pkg::*;
(
    input  logic [NCH-1:0]   rx_pend_i,
    input  logic [NCH-1:0]   tx_pend_i,
    input  logic [NCH-1:0]   tx_ie_i,
    input  logic [2*NCH-1:0] rx_mode_i,
    input  logic [NCH-1:0]   brk_ie_i,
    input  logic [NCH-1:0]   brk_stat_i,
    output logic             irq_o
);
    logic [NCH-1:0] req;

    for (genvar ch = 0; ch < NCH; ch++) begin : g_req
        logic [1:0] mode;
        logic       rx_on;
        assign mode  = rx_mode_i[2*ch +: 2];
        // Receive counts only in the two interrupting receive modes.
        assign rx_on = (mode == 2'b01) || (mode == 2'b10);
        assign req[ch] = (tx_ie_i[ch] & tx_pend_i[ch]) |
                         (rx_on & rx_pend_i[ch]) |
                         (brk_ie_i[ch] & brk_stat_i[ch]);
    end

    assign irq_o = |req;
endmodule

// File: rtl/sivec_ctrl.sv
// Module: top of the dual-channel interrupt vectoring block.
// Instantiates one state machine per channel, the shared register merge,
// and the request qualifier.
// Assumes event strobes are single-cycle pulses from the register-file logic.
module sivec_ctrl
    import sivec_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NCH-1:0]        rx_set_i,
    input  logic [NCH-1:0]        tx_set_i,
    input  logic [NCH-1:0]        rx_clr_i,
    input  logic [NCH-1:0]        tx_clr_i,
    input  logic [NCH-1:0]        ius_rst_i,
    input  logic [NCH-1:0]        tx_ie_i,
    input  logic [2*NCH-1:0]      rx_mode_i,
    input  logic [NCH-1:0]        brk_ie_i,
    input  logic [NCH-1:0]        brk_stat_i,
    input  logic                  stat_hi_i,
    output logic [PEND_W-1:0]     pend_o,
    output logic [VEC_W-1:0]      vec_o,
    output logic                  irq_o
);
    chan_upd_t [NCH-1:0] upd;
    logic [NCH-1:0]      rx_pend, tx_pend;

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        sivec_chan chan_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .rx_set_i  (rx_set_i[ch]),
            .tx_set_i  (tx_set_i[ch]),
            .rx_clr_i  (rx_clr_i[ch]),
            .tx_clr_i  (tx_clr_i[ch]),
            .ius_rst_i (ius_rst_i[ch]),
            .tx_ie_i   (tx_ie_i[ch]),
            .rx_pend_o (rx_pend[ch]),
            .tx_pend_o (tx_pend[ch]),
            .upd_o     (upd[ch])
        );
    end

    sivec_merge merge_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .stat_hi_i (stat_hi_i),
        .upd_i     (upd),
        .pend_o    (pend_o),
        .vec_o     (vec_o)
    );

    sivec_irq irq_i (
        .rx_pend_i  (rx_pend),
        .tx_pend_i  (tx_pend),
        .tx_ie_i    (tx_ie_i),
        .rx_mode_i  (rx_mode_i),
        .brk_ie_i   (brk_ie_i),
        .brk_stat_i (brk_stat_i),
        .irq_o      (irq_o)
    );
endmodule

// File: rtl/sivec_ctrl_chk.sv
// Checker: port-level properties of sivec_ctrl, attached through bind.
module sivec_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] rx_set_i,
    input logic [1:0] tx_set_i,
    input logic [1:0] rx_clr_i,
    input logic [1:0] tx_clr_i,
    input logic [1:0] ius_rst_i,
    input logic [1:0] tx_ie_i,
    input logic [1:0] brk_ie_i,
    input logic [1:0] brk_stat_i,
    input logic       stat_hi_i,
    input logic [5:0] pend_o,
    input logic [7:0] vec_o,
    input logic       irq_o
);
    logic quiet;
    assign quiet = ~|{rx_set_i, tx_set_i, rx_clr_i, tx_clr_i, ius_rst_i};

    // R4: a receive-set on channel A that wins arbitration sets bit 5.
    assert_rx_set_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_set_i[0] && !rx_clr_i[0] && !tx_clr_i[0]) |=> pend_o[5]);

    // R3: a lone channel A receive-set loads the receive code for the current placement.
    assert_rx_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_set_i[0] && !rx_clr_i[0] && !tx_clr_i[0] && rx_set_i[1] == 1'b0 &&
         tx_set_i[1] == 1'b0 && rx_clr_i[1] == 1'b0 && tx_clr_i[1] == 1'b0 && ius_rst_i[1] == 1'b0)
        |=> vec_o == ($past(stat_hi_i) ? 8'h30 : 8'h0C));

    // R6: a receive-clear drops the receive pending bit.
    assert_rx_clr_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_clr_i[0] |=> !pend_o[5]);

    // R6: a winning transmit-clear drops the transmit pending bit.
    assert_tx_clr_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_clr_i[0] && !rx_clr_i[0]) |=> !pend_o[4]);

    // R10: with no strobes the registers hold, whatever the placement select does.
    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        quiet |=> ($stable(vec_o) && $stable(pend_o)));

    // R8: nothing pending, transmit and break disabled means no request.
    assert_irq_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o == 6'h00 && tx_ie_i == 2'b00 && (brk_ie_i & brk_stat_i) == 2'b00) |-> !irq_o);
endmodule

bind sivec_ctrl sivec_ctrl_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_set_i   (rx_set_i),
    .tx_set_i   (tx_set_i),
    .rx_clr_i   (rx_clr_i),
    .tx_clr_i   (tx_clr_i),
    .ius_rst_i  (ius_rst_i),
    .tx_ie_i    (tx_ie_i),
    .brk_ie_i   (brk_ie_i),
    .brk_stat_i (brk_stat_i),
    .stat_hi_i  (stat_hi_i),
    .pend_o     (pend_o),
    .vec_o      (vec_o),
    .irq_o      (irq_o)
);

// File: tb/sivec_ctrl_tb_top.sv
module sivec_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NROWS = 18;
    // Row: {ev_a[4:0], ev_b[4:0], hi, tx_ie[1:0], pend[5:0], vec[7:0], irq}
    // ev bits: {rx_set, tx_set, rx_clr, tx_clr, ius_rst}
    localparam logic [27:0] TBL [NROWS] = '{
        {5'b10000, 5'b00000, 1'b0, 2'b11, 6'h20, 8'h0C, 1'b1},
        {5'b01000, 5'b00000, 1'b0, 2'b11, 6'h20, 8'h0C, 1'b1},
        {5'b00100, 5'b00000, 1'b0, 2'b11, 6'h10, 8'h08, 1'b1},
        {5'b00010, 5'b00000, 1'b0, 2'b11, 6'h00, 8'h06, 1'b0},
        {5'b00000, 5'b10000, 1'b1, 2'b11, 6'h04, 8'h20, 1'b1},
        {5'b00000, 5'b01000, 1'b1, 2'b11, 6'h04, 8'h20, 1'b1},
        {5'b00000, 5'b00001, 1'b1, 2'b11, 6'h06, 8'h00, 1'b1},
        {5'b00000, 5'b00001, 1'b1, 2'b11, 6'h06, 8'h00, 1'b1},
        {5'b00000, 5'b00010, 1'b1, 2'b11, 6'h04, 8'h20, 1'b1},
        {5'b00000, 5'b00100, 1'b1, 2'b11, 6'h00, 8'h60, 1'b0},
        {5'b10000, 5'b10000, 1'b0, 2'b11, 6'h24, 8'h0C, 1'b1},
        {5'b00000, 5'b00000, 1'b1, 2'b11, 6'h24, 8'h0C, 1'b1},
        {5'b00100, 5'b00100, 1'b0, 2'b00, 6'h00, 8'h06, 1'b0},
        {5'b01000, 5'b00000, 1'b0, 2'b00, 6'h00, 8'h08, 1'b0},
        {5'b00000, 5'b00000, 1'b0, 2'b01, 6'h00, 8'h08, 1'b1},
        {5'b00010, 5'b00000, 1'b0, 2'b01, 6'h00, 8'h06, 1'b0},
        {5'b00000, 5'b01000, 1'b0, 2'b11, 6'h02, 8'h00, 1'b1},
        {5'b00000, 5'b00010, 1'b0, 2'b11, 6'h00, 8'h06, 1'b0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] rx_set = '0, tx_set = '0, rx_clr = '0, tx_clr = '0, ius_rst = '0;
    logic [1:0] tx_ie = '0, brk_ie = '0, brk_stat = '0;
    logic [3:0] rx_mode = 4'b0101;
    logic       stat_hi = 1'b0;
    logic [5:0] pend;
    logic [7:0] vec;
    logic       irq;
    int         n_run = 0, n_fail = 0;
    bit         done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sivec_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .rx_set_i(rx_set), .tx_set_i(tx_set),
        .rx_clr_i(rx_clr), .tx_clr_i(tx_clr), .ius_rst_i(ius_rst),
        .tx_ie_i(tx_ie), .rx_mode_i(rx_mode), .brk_ie_i(brk_ie),
        .brk_stat_i(brk_stat), .stat_hi_i(stat_hi),
        .pend_o(pend), .vec_o(vec), .irq_o(irq)
    );

    function automatic string row_tag(input int r);
        case (r)
            0: return "R4";  1: return "R5";  2: return "R6";  3: return "R6";
            4: return "R3";  5: return "R5";  6: return "R7";  7: return "R7";
            8: return "R6";  9: return "R3";  10: return "R9"; 11: return "R10";
            12: return "R2"; 13: return "R5"; 14: return "R8"; 15: return "R6";
            16: return "R3"; default: return "R2";
        endcase
    endfunction

    task automatic check(input string tag, input logic [5:0] ep, input logic [7:0] ev, input logic ei);
        n_run++;
        if (pend !== ep || vec !== ev || irq !== ei) begin
            n_fail++;
            $display("FAIL %s: pend=%h vec=%h irq=%b expected pend=%h vec=%h irq=%b",
                     tag, pend, vec, irq, ep, ev, ei);
        end
    endtask

    // One strobe cycle, then strobes drop and the outputs are sampled.
    task automatic pulse(input logic [4:0] ea, input logic [4:0] eb);
        @(negedge clk);
        {rx_set[0], tx_set[0], rx_clr[0], tx_clr[0], ius_rst[0]} = ea;
        {rx_set[1], tx_set[1], rx_clr[1], tx_clr[1], ius_rst[1]} = eb;
        @(negedge clk);
        {rx_set, tx_set, rx_clr, tx_clr, ius_rst} = '0;
        #1;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_run++; n_fail++;
        $display("FAIL watchdog: run did not complete");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check("R1 reset state", 6'h00, 8'h00, 1'b0);
        @(negedge clk); rst_n = 1'b1;

        // Table walk.
        for (int r = 0; r < NROWS; r++) begin
            stat_hi = TBL[r][17];
            tx_ie   = TBL[r][16:15];
            pulse(TBL[r][27:23], TBL[r][22:18]);
            check(row_tag(r), TBL[r][14:9], TBL[r][8:1], TBL[r][0]);
        end

        // R9: receive-clear beats receive-set on one channel.
        stat_hi = 1'b1; tx_ie = 2'b00;
        pulse(5'b10100, 5'b00000);
        check("R9 same-channel priority", 6'h00, 8'h60, 1'b0);

        // R8: receive mode qualification on channel A.
        stat_hi = 1'b0;
        rx_mode = 4'b0100;
        pulse(5'b10000, 5'b00000);
        check("R8 mode 00", 6'h20, 8'h0C, 1'b0);
        rx_mode = 4'b0111; #1;
        check("R8 mode 11", 6'h20, 8'h0C, 1'b0);
        rx_mode = 4'b0110; #1;
        check("R8 mode 10", 6'h20, 8'h0C, 1'b1);
        rx_mode = 4'b0101;
        pulse(5'b00100, 5'b00000);
        check("R6 clear receive", 6'h00, 8'h06, 1'b0);

        // R8: break qualification on channel B.
        brk_ie = 2'b10; #1;
        check("R8 break enable only", 6'h00, 8'h06, 1'b0);
        brk_stat = 2'b10; #1;
        check("R8 break asserted", 6'h00, 8'h06, 1'b1);
        brk_ie = 2'b00; #1;
        check("R8 break disabled", 6'h00, 8'h06, 1'b0);
        brk_stat = 2'b00;

        // R1: reset from a busy state.
        pulse(5'b10000, 5'b10000);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); #1;
        check("R1 reset mid-run", 6'h00, 8'h00, 1'b0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule